// File: doc/BRIEF.md
# Host Interrupt Status Controller

This block gathers up to sixteen event lines raised inside the device and turns them into a single level-sensitive interrupt for a host processor. Each event latches into a status vector. A mask register decides which latched bits may reach the interrupt pin. The host reaches the block through a small word-addressed port with separate read and write strobes. Read data is registered and appears in the cycle after the read strobe.

The host has several ways to reach the status. It can sample the status without side effects through a peek view. It can drain all pending bits in one access through a take view. It can retire chosen bits by writing ones to an acknowledge address. The mask can be read directly. It is changed only through set and clear aliases that touch just the bits written as one, so no read-modify-write sequence is needed. A control word enables the interrupt pin and picks its active level.

Word addresses: 0 status peek, 1 status take, 2 mask (read only), 3 mask set, 4 mask clear, 5 acknowledge, 6 control. In the control word, bit 0 enables the pin and bit 1 makes it active-low.

Top module: `hirq_ctrl`

## Requirements
- R1: After reset the mask reads 0x0001, the status views and the control word read 0, and irq_out is low.
- R2: A write to address 3 ORs the written bits into the mask. Mask bits written as 0 keep their value.
- R3: A write to address 4 clears every mask bit written as 1. Mask bits written as 0 keep their value.
- R4: A write to address 5 clears each status bit written as 1, and both status views show the result. A write of 0 changes nothing.
- R5: A status bit is set after any cycle in which its event input is high. Only bits 0 to 10 and bit 14 exist. Bits 11, 12, 13 and 15 always read 0.
- R6: A read of address 0 returns the status and leaves it unchanged. A read of address 1 returns the status and clears every bit in the same access.
- R7: An event that arrives in the same cycle as an acknowledge or a take of its bit wins, so the bit is set afterwards.
- R8: irq_out equals (OR of status AND NOT mask) AND control bit 0, XOR control bit 1. It is combinational from the registered state.
- R9: Reads of addresses 3, 4, 5 and of unmapped addresses return 0. Writes to addresses 0, 1 and 2 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | 16 | Event inputs, one per status bit |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| irq_out | output | 1 | Host interrupt line |

## Verification
The hardest case to reach is a collision: an event that lands in the very cycle an acknowledge or a take retires the same bit. A ported view never shows both actions at once. The bench drives the event line and the bus strobe from the same falling-edge slot, so both arrive at one rising edge. It then uses a peek to confirm that the bit survived. For the take, it also confirms that the read returned the value from before the clear.

// File: rtl/hirq_pkg.sv
package hirq_pkg;
   localparam int HIRQ_A_PEEK = 0;
   localparam int HIRQ_A_TAKE = 1;
   localparam int HIRQ_A_MASK = 2;
   localparam int HIRQ_A_MSET = 3;
   localparam int HIRQ_A_MCLR = 4;
   localparam int HIRQ_A_ACK  = 5;
   localparam int HIRQ_A_CTRL = 6;
   localparam int HIRQ_MIN_AW = 3;
   localparam int HIRQ_CTRL_W = 2;

   typedef struct packed {
      logic act_low;
      logic enable;
   } hirq_ctrl_t;
endpackage

// File: rtl/hirq_mask_reg.sv
module hirq_mask_reg #(
   parameter int N = 16,
   parameter logic [N-1:0] RST_VAL = 'h1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [N-1:0] bits,
   output logic [N-1:0] mask
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         mask <= RST_VAL;
      else if (set_we)
         mask <= mask | bits;
      else if (clr_we)
         mask <= mask & ~bits;
   end

   AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> ((mask & $past(bits)) == $past(bits)));       // R2
   AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && !set_we) |=> ((mask & $past(bits)) == '0));   // R3
   AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_we && !clr_we) |=> $stable(mask));                 // R2
endmodule

// File: rtl/hirq_status_reg.sv
module hirq_status_reg #(
   parameter int N = 16,
   parameter logic [N-1:0] USED = 'h47FF
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt,
   input  logic         take,
   input  logic         ack_we,
   input  logic [N-1:0] ack_bits,
   output logic [N-1:0] sts
);
   logic [N-1:0] unused_in;

   for (genvar i = 0; i < N; i++) begin : g_bit
      if (USED[i]) begin : g_live
         logic drop;
         assign drop = take | (ack_we & ack_bits[i]);
         always_ff @(posedge clk) begin
            if (!rst_n)
               sts[i] <= 1'b0;
            else
               sts[i] <= evt[i] | (sts[i] & ~drop);
         end
         assign unused_in[i] = 1'b0;
      end else begin : g_tie
         assign sts[i] = 1'b0;
         assign unused_in[i] = evt[i] ^ ack_bits[i];
      end
   end

   AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      |(evt & USED) |=> ((sts & $past(evt & USED)) == $past(evt & USED)));   // R5
   AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      ack_we |=> ((sts & $past(ack_bits & ~evt)) == '0));                    // R4
   AST_TAKE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> ((sts & ~$past(evt)) == '0));                                 // R6
   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && !ack_we && evt == '0) |=> $stable(sts));                     // R6
endmodule

// File: rtl/hirq_out_drv.sv
module hirq_out_drv #(
   parameter int N = 16,
   parameter bit OUT_REG = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] sts,
   input  logic [N-1:0] mask,
   input  logic         enable,
   input  logic         act_low,
   output logic         irq
);
   logic pend;
   logic lvl;

   assign pend = |(sts & ~mask);
   assign lvl  = (pend & enable) ^ act_low;

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            irq <= 1'b0;
         else
            irq <= lvl;
      end
   end else begin : g_comb
      assign irq = lvl;
      AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         !enable |-> (irq == act_low));                       // R8
   end
endmodule

// File: rtl/hirq_ctrl.sv
module hirq_ctrl
   import hirq_pkg::*;
#(
   parameter int N_EVT  = 16,
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32,
   parameter logic [N_EVT-1:0] MASK_RST  = 16'h0001,
   parameter logic [N_EVT-1:0] USED_BITS = 16'h47FF,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_EVT-1:0]  evt_in,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq_out
);
   localparam int PAD_W = DATA_W - N_EVT;

   if (N_EVT > DATA_W || N_EVT < HIRQ_CTRL_W) begin : g_bad_w
      initial $fatal(1, "hirq_ctrl: N_EVT must be in [2, DATA_W]");
   end
   if (ADDR_W < HIRQ_MIN_AW) begin : g_bad_a
      initial $fatal(1, "hirq_ctrl: ADDR_W too small for the map");
   end

   logic hit_take, hit_mset, hit_mclr, hit_ack, hit_ctrl;
   assign hit_take = rd_en && addr == ADDR_W'(HIRQ_A_TAKE);
   assign hit_mset = wr_en && addr == ADDR_W'(HIRQ_A_MSET);
   assign hit_mclr = wr_en && addr == ADDR_W'(HIRQ_A_MCLR);
   assign hit_ack  = wr_en && addr == ADDR_W'(HIRQ_A_ACK);
   assign hit_ctrl = wr_en && addr == ADDR_W'(HIRQ_A_CTRL);

   logic [N_EVT-1:0] wbits;
   assign wbits = wdata[N_EVT-1:0];

   if (PAD_W > 0) begin : g_pad
      logic unused_hi;
      assign unused_hi = ^wdata[DATA_W-1:N_EVT];
   end

   logic [N_EVT-1:0] mask;
   logic [N_EVT-1:0] sts;
   hirq_ctrl_t       ctl;

   hirq_mask_reg #(.N(N_EVT), .RST_VAL(MASK_RST)) u_mask (
      .clk(clk), .rst_n(rst_n), .set_we(hit_mset), .clr_we(hit_mclr),
      .bits(wbits), .mask(mask));

   hirq_status_reg #(.N(N_EVT), .USED(USED_BITS)) u_sts (
      .clk(clk), .rst_n(rst_n), .evt(evt_in), .take(hit_take),
      .ack_we(hit_ack), .ack_bits(wbits), .sts(sts));

   always_ff @(posedge clk) begin
      if (!rst_n)
         ctl <= '0;
      else if (hit_ctrl)
         ctl <= hirq_ctrl_t'(wdata[HIRQ_CTRL_W-1:0]);
   end

   hirq_out_drv #(.N(N_EVT), .OUT_REG(OUT_REG)) u_out (
      .clk(clk), .rst_n(rst_n), .sts(sts), .mask(mask),
      .enable(ctl.enable), .act_low(ctl.act_low), .irq(irq_out));

   logic [DATA_W-1:0] rd_val;
   always_comb begin
      rd_val = '0;
      case (addr)
         ADDR_W'(HIRQ_A_PEEK),
         ADDR_W'(HIRQ_A_TAKE): rd_val[N_EVT-1:0] = sts;
         ADDR_W'(HIRQ_A_MASK): rd_val[N_EVT-1:0] = mask;
         ADDR_W'(HIRQ_A_CTRL): rd_val[HIRQ_CTRL_W-1:0] = ctl;
         default:              rd_val = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata <= '0;
      else if (rd_en)
         rdata <= rd_val;
   end

   AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (addr == ADDR_W'(HIRQ_A_MSET) || addr == ADDR_W'(HIRQ_A_MCLR)
                 || addr == ADDR_W'(HIRQ_A_ACK))) |=> (rdata == '0));   // R9
   AST_RO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(HIRQ_A_MASK)) |=> $stable(mask));       // R9
   AST_TAKE_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
      hit_take |=> (rdata[N_EVT-1:0] == $past(sts)));                   // R6
endmodule

// File: tb/sim_hirq_ctrl.sv
module sim_hirq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] evt_in = '0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq_out;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   hirq_ctrl u0 (.clk(clk), .rst_n(rst_n), .evt_in(evt_in), .wr_en(wr_en),
                 .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
                 .irq_out(irq_out));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0; wdata = '0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk); rd_en = 1'b1; addr = a;
      @(negedge clk); rd_en = 1'b0; d = rdata;
   endtask

   task automatic pulse(input logic [15:0] v);
      @(negedge clk); evt_in = v;
      @(negedge clk); evt_in = '0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R1 irq", {31'b0, irq_out}, 32'h0);
      rd(2, d); chk("R1 mask", d, 32'h0001);
      rd(0, d); chk("R1 status", d, 32'h0);
      rd(6, d); chk("R1 ctrl", d, 32'h0);
   endtask

   task automatic t_latch();
      logic [31:0] d;
      pulse(16'hFFFF);
      rd(0, d); chk("R5 used bits only", d, 32'h47FF);
      rd(0, d); chk("R6 peek keeps", d, 32'h47FF);
      rd(1, d); chk("R6 take returns", d, 32'h47FF);
      rd(0, d); chk("R6 take clears", d, 32'h0);
   endtask

   task automatic t_ack();
      logic [31:0] d;
      pulse(16'h0413);
      wr(5, 32'h0011);
      rd(0, d); chk("R4 ack peek", d, 32'h0402);
      rd(1, d); chk("R4 ack take view", d, 32'h0402);
      pulse(16'h0006);
      wr(5, 32'h0);
      rd(0, d); chk("R4 ack zero", d, 32'h0006);
      rd(1, d);
   endtask

   task automatic t_mask();
      logic [31:0] d;
      wr(4, 32'hFFFF); rd(2, d); chk("R3 clear all", d, 32'h0);
      wr(3, 32'h0081); rd(2, d); chk("R2 set", d, 32'h0081);
      wr(3, 32'h0300); rd(2, d); chk("R2 set keeps", d, 32'h0381);
      wr(4, 32'h0101); rd(2, d); chk("R3 clear some", d, 32'h0280);
      wr(4, 32'h0);    rd(2, d); chk("R3 clear zero", d, 32'h0280);
      wr(4, 32'hFFFF); wr(3, 32'h0001);
   endtask

   task automatic t_irq();
      logic [31:0] d;
      pulse(16'h0001);
      wr(6, 32'h1);
      chk("R8 masked", {31'b0, irq_out}, 32'h0);
      pulse(16'h0002);
      chk("R8 fires", {31'b0, irq_out}, 32'h1);
      wr(6, 32'h3);
      chk("R8 active low", {31'b0, irq_out}, 32'h0);
      rd(6, d); chk("R8 ctrl read", d, 32'h3);
      wr(5, 32'h0002);
      chk("R8 idle low-active", {31'b0, irq_out}, 32'h1);
      wr(4, 32'h0001);
      chk("R8 unmask", {31'b0, irq_out}, 32'h0);
      wr(6, 32'h2);
      chk("R8 disabled", {31'b0, irq_out}, 32'h1);
      wr(6, 32'h0);
      chk("R8 off", {31'b0, irq_out}, 32'h0);
      rd(1, d); wr(3, 32'h0001);
   endtask

   task automatic t_collide();
      logic [31:0] d;
      pulse(16'h0004);
      @(negedge clk); evt_in = 16'h0004; wr_en = 1'b1; addr = 4'd5; wdata = 32'h0004;
      @(negedge clk); evt_in = '0; wr_en = 1'b0; wdata = '0;
      rd(0, d); chk("R7 event beats ack", d, 32'h0004);
      @(negedge clk); evt_in = 16'h0020; rd_en = 1'b1; addr = 4'd1;
      @(negedge clk); evt_in = '0; rd_en = 1'b0;
      chk("R7 take old value", rdata, 32'h0004);
      rd(0, d); chk("R7 event beats take", d, 32'h0020);
      rd(1, d);
   endtask

   task automatic t_map();
      logic [31:0] d;
      rd(3, d); chk("R9 mset reads 0", d, 32'h0);
      rd(4, d); chk("R9 mclr reads 0", d, 32'h0);
      rd(5, d); chk("R9 ack reads 0", d, 32'h0);
      rd(7, d); chk("R9 unmapped 7", d, 32'h0);
      rd(15, d); chk("R9 unmapped 15", d, 32'h0);
      pulse(16'h0001);
      wr(0, 32'hFFFF); rd(0, d); chk("R9 peek write ignored", d, 32'h0001);
      wr(1, 32'hFFFF); rd(0, d); chk("R9 take write ignored", d, 32'h0001);
      wr(2, 32'h0);    rd(2, d); chk("R9 mask write ignored", d, 32'h0001);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_latch();
      t_ack();
      t_mask();
      t_irq();
      t_collide();
      t_map();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule